// File: doc/BRIEF.md
# Removable Card Configuration and Status Registers

This block holds the small control register set that a removable flash card exposes in its attribute space. A host writes a soft-reset control through a write-only option register and a sleep control through a configuration register. It reads back a status register that shows both controls together with the combined ready state of every memory device. The two controls go straight to the memory array as a reset line and a power-down line.

The host side is a plain byte-wide register port: address, write data, a write strobe and a read strobe. Read data is registered and appears on the clock after the read strobe. Each device's ready line is resynchronised through two flops, and the lines are then ANDed, so the polled ready bit reflects the whole array and never glitches. A build parameter removes the whole register set for cards that have no attribute memory. The ready path stays in place in that case.

Top module: `card_cfg_regs`

## Requirements
- R1: A write to address 0x4000 with bit 7 set drives `array_reset` high from the next cycle, and it stays high while the bit stays set.
- R2: Bits 6..0 of a write to 0x4000 are ignored. They leave `array_pwrdn` and the status bits other than bit 5 unchanged.
- R3: A write to 0x4002 stores bit 2 as the power-down control and drives `array_pwrdn` from the next cycle. Its other bits are ignored. Reading 0x4002 returns the control in bit 2 and 0 in all other bits.
- R4: Reading 0x4100 returns the soft-reset bit in bit 5, the power-down bit in bit 3 and card ready in bit 0 (1 = ready). All other bits read 0.
- R5: `card_ready` is high only when every `dev_ready` input is high. It follows the inputs as they were sampled two clock edges earlier.
- R6: While `rst` is high, `array_reset` is high. After `rst`, the soft-reset bit, the power-down bit, the synchroniser flops and `rdata` are all 0.
- R7: `rdata` is valid in the cycle after `rd_en`. It is 0 when no read was made, for reads of 0x4000 and for reads of unmapped addresses.
- R8: After the soft-reset bit is cleared, `array_reset` stays high for exactly one more cycle and then goes low.
- R9: A read and a write in the same cycle to the same register return the value held before that write.
- R10: With `HAS_REGS` = 0, no register exists. Writes do not affect `array_reset` or `array_pwrdn` outside `rst`, and every read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high card reset |
| addr | input | ADDR_W | Attribute register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| rdata | output | 8 | Registered read data |
| dev_ready | input | NUM_DEV | Per-device ready lines, 1 = ready |
| card_ready | output | 1 | Combined synchronised ready |
| array_reset | output | 1 | Reset to the memory array |
| array_pwrdn | output | 1 | Power-down to the memory array |

## Verification
A read and a write can hit the configuration register in the same cycle. The bench drives both strobes together on 0x4002 and expects the read to return the old power-down value, with the new value showing only on the following read. It also issues a status read in the very cycle a device goes busy. Because of the two-stage synchroniser, that read must still report ready, while a read two cycles later must report busy.

// File: rtl/card_cfg_regs.sv
module card_cfg_regs #(
  parameter int ADDR_W   = 15,
  parameter int NUM_DEV  = 4,
  parameter bit HAS_REGS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic [NUM_DEV-1:0] dev_ready,
  output logic              card_ready,
  output logic              array_reset,
  output logic              array_pwrdn
);
  localparam logic [ADDR_W-1:0] OPT_ADDR  = ADDR_W'('h4000);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'('h4002);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h4100);

  logic [NUM_DEV-1:0] rdy_s1, rdy_s2;
  logic soft_q, pd_q, hold_q;
  logic [7:0] rd_q;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_s1 <= '0;
      rdy_s2 <= '0;
      age    <= '0;
    end else begin
      rdy_s1 <= dev_ready;
      rdy_s2 <= rdy_s1;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign card_ready  = &rdy_s2;
  assign array_reset = rst | soft_q | hold_q;
  assign array_pwrdn = pd_q;
  assign rdata       = rd_q;

  AST_READY_SYNC: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (card_ready == &$past(dev_ready, 2))); // R5

  generate
    if (HAS_REGS) begin : g_regs
      wire wr_opt = wr_en && (addr == OPT_ADDR);
      wire wr_cfg = wr_en && (addr == CFG_ADDR);
      wire [7:0] status = {2'b00, soft_q, 1'b0, pd_q, 2'b00, card_ready};
      logic unused_wbits;
      assign unused_wbits = ^{wdata[6:3], wdata[1:0]};

      always_ff @(posedge clk) begin
        if (rst) begin
          soft_q <= 1'b0;
          pd_q   <= 1'b0;
          hold_q <= 1'b0;
          rd_q   <= '0;
        end else begin
          if (wr_opt) soft_q <= wdata[7];
          if (wr_cfg) pd_q   <= wdata[2];
          hold_q <= soft_q;
          if (!rd_en)                 rd_q <= '0;
          else if (addr == CFG_ADDR)  rd_q <= {5'b0, pd_q, 2'b00};
          else if (addr == STAT_ADDR) rd_q <= status;
          else                        rd_q <= '0;
        end
      end

      AST_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
        wr_opt && wdata[7] |=> array_reset); // R1
      AST_OPT_NO_PD: assert property (@(posedge clk) disable iff (rst)
        wr_opt |=> $stable(array_pwrdn)); // R2
      AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        wr_cfg |=> (array_pwrdn == $past(wdata[2]))); // R3
      AST_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) == STAT_ADDR) |-> ((rdata & 8'hD6) == 8'h00)); // R4
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata == 8'h00)); // R7
      AST_SOFT_REL: assert property (@(posedge clk) disable iff (rst)
        (wr_opt && !wdata[7]) ##1 !(wr_opt && wdata[7]) |=> !array_reset); // R8
    end else begin : g_none
      logic unused_bus;
      assign unused_bus = ^{addr, wdata, wr_en, rd_en};
      assign soft_q = 1'b0;
      assign pd_q   = 1'b0;
      assign hold_q = 1'b0;
      assign rd_q   = '0;
      AST_BARE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !array_reset && !array_pwrdn && rdata == 8'h00); // R10
    end
  endgenerate
endmodule

// File: tb/card_cfg_regs_test.sv
module card_cfg_regs_test;
  localparam int AW = 15;
  localparam int ND = 4;
  localparam logic [AW-1:0] A_OPT  = 15'h4000;
  localparam logic [AW-1:0] A_CFG  = 15'h4002;
  localparam logic [AW-1:0] A_STAT = 15'h4100;
  localparam logic [AW-1:0] A_NONE = 15'h4004;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ND-1:0] dev_ready = '1;
  logic [7:0] rdata, b_rdata;
  logic card_ready, array_reset, array_pwrdn;
  logic b_ready, b_reset, b_pwrdn;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  card_cfg_regs #(.ADDR_W(AW), .NUM_DEV(ND), .HAS_REGS(1'b1)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .dev_ready(dev_ready), .card_ready(card_ready),
    .array_reset(array_reset), .array_pwrdn(array_pwrdn));

  card_cfg_regs #(.ADDR_W(AW), .NUM_DEV(ND), .HAS_REGS(1'b0)) uut_bare (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(b_rdata), .dev_ready(dev_ready), .card_ready(b_ready),
    .array_reset(b_reset), .array_pwrdn(b_pwrdn));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [AW-1:0] a, input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rd_en && !rst) begin
      #2;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected read actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    total++; bad++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset drives array_reset", {7'b0, array_reset}, 8'h01);
    chk("R6 reset clears pwrdn", {7'b0, array_pwrdn}, 8'h00);
    chk("R6 reset clears sync", {7'b0, card_ready}, 8'h00);
    chk("R6 reset clears rdata", rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 array_reset low after rst", {7'b0, array_reset}, 8'h00);
    repeat (2) @(negedge clk);
    chk("R5 all ready", {7'b0, card_ready}, 8'h01);
    rd(A_STAT, 8'h01, "R4 idle status");
    rd(A_OPT, 8'h00, "R7 option reg reads zero");
    rd(A_NONE, 8'h00, "R7 unmapped reads zero");
    chk("R7 rdata zero without read", rdata, 8'h00);

    wr(A_OPT, 8'h7F);
    chk("R2 low bits no reset", {7'b0, array_reset}, 8'h00);
    chk("R2 low bits no pwrdn", {7'b0, array_pwrdn}, 8'h00);
    rd(A_STAT, 8'h01, "R2 status unchanged");

    wr(A_OPT, 8'h80);
    chk("R1 soft reset asserted", {7'b0, array_reset}, 8'h01);
    chk("R10 bare no reset", {7'b0, b_reset}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R1 soft reset held", {7'b0, array_reset}, 8'h01);
    rd(A_STAT, 8'h21, "R4 status soft bit");
    chk("R10 bare reads zero", b_rdata, 8'h00);

    wr(A_OPT, 8'h00);
    chk("R8 reset held one cycle", {7'b0, array_reset}, 8'h01);
    @(negedge clk);
    chk("R8 reset released", {7'b0, array_reset}, 8'h00);
    rd(A_STAT, 8'h01, "R4 status soft cleared");

    wr(A_CFG, 8'h04);
    chk("R3 pwrdn set", {7'b0, array_pwrdn}, 8'h01);
    chk("R10 bare no pwrdn", {7'b0, b_pwrdn}, 8'h00);
    rd(A_STAT, 8'h09, "R4 status pd bit");
    rd(A_CFG, 8'h04, "R3 cfg readback");
    wr(A_CFG, 8'hFB);
    chk("R3 pwrdn cleared", {7'b0, array_pwrdn}, 8'h00);
    rd(A_CFG, 8'h00, "R3 other bits ignored");

    rdwr(A_CFG, 8'h04, 8'h00, "R9 read returns old value");
    rd(A_CFG, 8'h04, "R9 new value next read");
    wr(A_CFG, 8'h00);

    @(negedge clk); dev_ready[2] = 1'b0; addr = A_STAT; rd_en = 1'b1;
    exp_q.push_back(8'h01); tag_q.push_back("R5 busy not yet visible");
    @(negedge clk); rd_en = 1'b0;
    chk("R5 one edge still ready", {7'b0, card_ready}, 8'h01);
    @(negedge clk);
    chk("R5 busy after two edges", {7'b0, card_ready}, 8'h00);
    rd(A_STAT, 8'h00, "R4 status busy");
    dev_ready[2] = 1'b1;
    dev_ready[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 other device busy", {7'b0, card_ready}, 8'h00);
    dev_ready = '1;
    repeat (2) @(negedge clk);
    chk("R5 ready again", {7'b0, card_ready}, 8'h01);

    wr(A_OPT, 8'h80);
    wr(A_CFG, 8'h04);
    rd(A_STAT, 8'h29, "R4 both bits");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R6 pwrdn cleared by rst", {7'b0, array_pwrdn}, 8'h00);
    @(negedge clk);
    chk("R6 soft cleared by rst", {7'b0, array_reset}, 8'h00);
    repeat (2) @(negedge clk);
    rd(A_STAT, 8'h01, "R6 status after rst");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule